// File: doc/BRIEF.md
# Cross-Clock Mailbox Bypass Pair

This block carries single command words between two independently clocked ports without passing them through the data queue. It has two mailboxes. Mailbox 1 is loaded from port A and read at port B. Mailbox 2 is loaded from port B and read at port A. Each mailbox has an active-low "mail pending" flag in the writer's clock domain. While that flag is low, further writes to the same mailbox are refused. The reader's domain has its own active-high pending indication. A qualified read there retires the word. After the handshake reaches the writer's domain, the writer's flag returns high.

The write and read events cross between the clocks as toggles through flop synchronizers. Each flag is therefore a compare of two toggles inside one clock domain, and no flop is driven from two clocks. The stored word stays stable for the whole time the reader can see it. Each port also has an output multiplexer, steered by that port's mailbox select. It routes either the incoming mailbox or the queue's output register (an input to this block) to the port's read data. Each mailbox is cleared by the reset of its associated queue. The reset is asynchronous and active low.

Top module: `mailbox_bypass`

## Requirements
- R1: Each mailbox holds a DATA_W-bit word (36 by default). A word written at one port is returned unchanged at the other port's read data.
- R2: A port A write qualifies when selAN=0, dirWriteA=1, enA=1 and mboxSelA=1 while mail1FlagN is high. It stores dinA into mailbox 1 on that clkA rising edge, and mail1FlagN is low directly after that edge.
- R3: A qualified-looking write while the mailbox flag is low is ignored. The stored word does not change and the flag stays low.
- R4: The reader's pending output (mail1Pending) is still low at the first reader-clock falling edge after the write edge. It goes high within the next synchronizer delay, that is by the fourth reader falling edge. It rises only while the writer's flag is low.
- R5: A port B read qualifies when selBN=0, dirReadB=1, enB=1 and mboxSelB=1 while mail1Pending is high. It clears mail1Pending on that clkB edge. mail1FlagN is still low at the first clkA falling edge after the read edge and is high by the fourth.
- R6: Reading a mailbox leaves its contents unchanged.
- R7: A read made while nothing is pending has no effect: pending stays low, the writer's flag stays high and the contents are unchanged.
- R8: A low level on a mailbox's reset forces that mailbox's writer flag high, its reader pending low and its contents to zero.
- R9: At each port, mailbox select high routes the incoming mailbox (port A: mailbox 2, port B: mailbox 1) to the read data. Mailbox select low routes that port's queue output register input.
- R10: Mailbox 2 works in the mirror direction. A write qualifies when selBN=0, dirReadB=0, enB=1 and mboxSelB=1, with mail2FlagN on clkB. A read qualifies when selAN=0, dirWriteA=0, enA=1 and mboxSelA=1, with mail2Pending on clkA.
- R11: A port A cycle with enA=0, selAN=1 or mboxSelA=0 stores nothing in mailbox 1 and leaves mail1FlagN high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clkA | input | 1 | Port A clock |
| clkB | input | 1 | Port B clock |
| fifo1RstN | input | 1 | Async active-low reset of the A-to-B queue; clears mailbox 1 |
| fifo2RstN | input | 1 | Async active-low reset of the B-to-A queue; clears mailbox 2 |
| selAN | input | 1 | Port A select, active low |
| dirWriteA | input | 1 | Port A direction: 1 write, 0 read |
| enA | input | 1 | Port A transfer enable |
| mboxSelA | input | 1 | Port A mailbox select |
| dinA | input | DATA_W | Port A write data |
| fifoOutA | input | DATA_W | Queue output register seen at port A |
| doutA | output | DATA_W | Port A read data |
| mail1FlagN | output | 1 | Mailbox 1 writer flag, low while mail is pending (clkA) |
| mail2Pending | output | 1 | Mailbox 2 pending as seen at port A (clkA) |
| selBN | input | 1 | Port B select, active low |
| dirReadB | input | 1 | Port B direction: 1 read, 0 write |
| enB | input | 1 | Port B transfer enable |
| mboxSelB | input | 1 | Port B mailbox select |
| dinB | input | DATA_W | Port B write data |
| fifoOutB | input | DATA_W | Queue output register seen at port B |
| doutB | output | DATA_W | Port B read data |
| mail2FlagN | output | 1 | Mailbox 2 writer flag, low while mail is pending (clkB) |
| mail1Pending | output | 1 | Mailbox 1 pending as seen at port B (clkB) |

## Verification
The writer's flag falls on the same edge as the write. It is checked one nanosecond after that edge. The read-side pending falls on the read edge and is checked in the same way. The read-data multiplexer is combinational and is checked right after its select changes. The cross-domain results take a synchronizer delay, and with a free phase between the clocks that delay cannot be pinned to a single edge. For these, the bench counts falling edges of the receiving clock. It requires the result to be absent at the first falling edge and present by the fourth. This check is repeated for several clock-B half periods so that the phase relation moves.

// File: rtl/mbox_pkg.sv
`timescale 1ns/1ps
package mbox_pkg;
  // Load strobes from control to datapath, one per mailbox
  typedef struct packed {
    logic load1;   // capture port A data into mailbox 1 (clkA)
    logic load2;   // capture port B data into mailbox 2 (clkB)
  } mboxStrobes_t;
endpackage

// File: rtl/mbox_sync.sv
`timescale 1ns/1ps
module mbox_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic d,
  output logic q
);
  logic stage [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stage[i] <= 1'b0;
        else       stage[i] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stage[i] <= 1'b0;
        else       stage[i] <= stage[i-1];
      end
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/mbox_link.sv
`timescale 1ns/1ps
// One mailbox handshake: writer toggle and reader toggle, each mirrored
// into the other domain, each flag compared locally.
module mbox_link #(
  parameter int SYNC_STAGES = 2
) (
  input  logic wrClk,
  input  logic rdClk,
  input  logic rstN,
  input  logic wrReq,
  input  logic rdReq,
  output logic load,
  output logic flagN,
  output logic pending
);
  logic wrTog, rdTog;
  logic rdTogAtWr, wrTogAtRd;

  assign flagN   = (wrTog == rdTogAtWr);
  assign load    = wrReq & flagN;
  assign pending = wrTogAtRd ^ rdTog;

  always_ff @(posedge wrClk or negedge rstN) begin
    if (!rstN)     wrTog <= 1'b0;
    else if (load) wrTog <= ~wrTog;
  end

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN)                  rdTog <= 1'b0;
    else if (rdReq && pending)  rdTog <= ~rdTog;
  end

  mbox_sync #(.STAGES(SYNC_STAGES)) u_wrToRd (
    .clk(rdClk), .rstN(rstN), .d(wrTog), .q(wrTogAtRd)
  );

  mbox_sync #(.STAGES(SYNC_STAGES)) u_rdToWr (
    .clk(wrClk), .rstN(rstN), .d(rdTog), .q(rdTogAtWr)
  );
endmodule

// File: rtl/mbox_ctrl.sv
`timescale 1ns/1ps
module mbox_ctrl
  import mbox_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic         clkA,
  input  logic         clkB,
  input  logic         fifo1RstN,
  input  logic         fifo2RstN,
  input  logic         selAN,
  input  logic         dirWriteA,
  input  logic         enA,
  input  logic         mboxSelA,
  input  logic         selBN,
  input  logic         dirReadB,
  input  logic         enB,
  input  logic         mboxSelB,
  output mboxStrobes_t strobes,
  output logic         mail1FlagN,
  output logic         mail1Pending,
  output logic         mail2FlagN,
  output logic         mail2Pending
);
  logic portAMbox, portBMbox;
  logic wr1Req, rd1Req, wr2Req, rd2Req;
  logic load1, load2;

  assign portAMbox = !selAN && enA && mboxSelA;
  assign portBMbox = !selBN && enB && mboxSelB;
  assign wr1Req    = portAMbox &&  dirWriteA;
  assign rd2Req    = portAMbox && !dirWriteA;
  assign wr2Req    = portBMbox && !dirReadB;
  assign rd1Req    = portBMbox &&  dirReadB;

  mbox_link #(.SYNC_STAGES(SYNC_STAGES)) u_link1 (
    .wrClk(clkA), .rdClk(clkB), .rstN(fifo1RstN),
    .wrReq(wr1Req), .rdReq(rd1Req),
    .load(load1), .flagN(mail1FlagN), .pending(mail1Pending)
  );

  mbox_link #(.SYNC_STAGES(SYNC_STAGES)) u_link2 (
    .wrClk(clkB), .rdClk(clkA), .rstN(fifo2RstN),
    .wrReq(wr2Req), .rdReq(rd2Req),
    .load(load2), .flagN(mail2FlagN), .pending(mail2Pending)
  );

  assign strobes.load1 = load1;
  assign strobes.load2 = load2;
endmodule

// File: rtl/mbox_datapath.sv
`timescale 1ns/1ps
module mbox_datapath
  import mbox_pkg::*;
#(
  parameter int DATA_W = 36
) (
  input  logic              clkA,
  input  logic              clkB,
  input  logic              fifo1RstN,
  input  logic              fifo2RstN,
  input  mboxStrobes_t      strobes,
  input  logic [DATA_W-1:0] dinA,
  input  logic [DATA_W-1:0] dinB,
  input  logic [DATA_W-1:0] fifoOutA,
  input  logic [DATA_W-1:0] fifoOutB,
  input  logic              mboxSelA,
  input  logic              mboxSelB,
  output logic [DATA_W-1:0] doutA,
  output logic [DATA_W-1:0] doutB,
  output logic [DATA_W-1:0] mbox1Q,
  output logic [DATA_W-1:0] mbox2Q
);
  always_ff @(posedge clkA or negedge fifo1RstN) begin
    if (!fifo1RstN)         mbox1Q <= '0;
    else if (strobes.load1) mbox1Q <= dinA;
  end

  always_ff @(posedge clkB or negedge fifo2RstN) begin
    if (!fifo2RstN)         mbox2Q <= '0;
    else if (strobes.load2) mbox2Q <= dinB;
  end

  assign doutA = mboxSelA ? mbox2Q : fifoOutA;
  assign doutB = mboxSelB ? mbox1Q : fifoOutB;
endmodule

// File: rtl/mailbox_bypass.sv
`timescale 1ns/1ps
module mailbox_bypass
  import mbox_pkg::*;
#(
  parameter int DATA_W      = 36,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clkA,
  input  logic              clkB,
  input  logic              fifo1RstN,
  input  logic              fifo2RstN,
  input  logic              selAN,
  input  logic              dirWriteA,
  input  logic              enA,
  input  logic              mboxSelA,
  input  logic [DATA_W-1:0] dinA,
  input  logic [DATA_W-1:0] fifoOutA,
  output logic [DATA_W-1:0] doutA,
  output logic              mail1FlagN,
  output logic              mail2Pending,
  input  logic              selBN,
  input  logic              dirReadB,
  input  logic              enB,
  input  logic              mboxSelB,
  input  logic [DATA_W-1:0] dinB,
  input  logic [DATA_W-1:0] fifoOutB,
  output logic [DATA_W-1:0] doutB,
  output logic              mail2FlagN,
  output logic              mail1Pending
);
  mboxStrobes_t      strobes;
  logic [DATA_W-1:0] mbox1Q, mbox2Q;

  mbox_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clkA(clkA), .clkB(clkB), .fifo1RstN(fifo1RstN), .fifo2RstN(fifo2RstN),
    .selAN(selAN), .dirWriteA(dirWriteA), .enA(enA), .mboxSelA(mboxSelA),
    .selBN(selBN), .dirReadB(dirReadB), .enB(enB), .mboxSelB(mboxSelB),
    .strobes(strobes),
    .mail1FlagN(mail1FlagN), .mail1Pending(mail1Pending),
    .mail2FlagN(mail2FlagN), .mail2Pending(mail2Pending)
  );

  mbox_datapath #(.DATA_W(DATA_W)) u_dp (
    .clkA(clkA), .clkB(clkB), .fifo1RstN(fifo1RstN), .fifo2RstN(fifo2RstN),
    .strobes(strobes), .dinA(dinA), .dinB(dinB),
    .fifoOutA(fifoOutA), .fifoOutB(fifoOutB),
    .mboxSelA(mboxSelA), .mboxSelB(mboxSelB),
    .doutA(doutA), .doutB(doutB), .mbox1Q(mbox1Q), .mbox2Q(mbox2Q)
  );
endmodule

// File: rtl/mailbox_bypass_chk.sv
`timescale 1ns/1ps
module mailbox_bypass_chk #(
  parameter int DATA_W = 36
) (
  input logic              clkA,
  input logic              clkB,
  input logic              fifo1RstN,
  input logic              fifo2RstN,
  input logic              selAN,
  input logic              dirWriteA,
  input logic              enA,
  input logic              mboxSelA,
  input logic              selBN,
  input logic              dirReadB,
  input logic              enB,
  input logic              mboxSelB,
  input logic              mail1FlagN,
  input logic              mail1Pending,
  input logic              mail2FlagN,
  input logic              mail2Pending,
  input logic [DATA_W-1:0] mbox1Q,
  input logic [DATA_W-1:0] mbox2Q
);
  logic wrA1, rdB1, wrB2, rdA2;
  assign wrA1 = !selAN &&  dirWriteA && enA && mboxSelA;
  assign rdA2 = !selAN && !dirWriteA && enA && mboxSelA;
  assign wrB2 = !selBN && !dirReadB  && enB && mboxSelB;
  assign rdB1 = !selBN &&  dirReadB  && enB && mboxSelB;

  // R2
  wr1_sets_flag_chk: assert property (@(posedge clkA) disable iff (!fifo1RstN)
    (wrA1 && mail1FlagN) |=> !mail1FlagN);
  // R2
  flag1_fall_src_chk: assert property (@(posedge clkA) disable iff (!fifo1RstN)
    $fell(mail1FlagN) |-> $past(wrA1));
  // R3
  blocked1_chk: assert property (@(posedge clkA) disable iff (!fifo1RstN)
    !mail1FlagN |=> $stable(mbox1Q));
  // R4
  pend1_rise_chk: assert property (@(posedge clkB) disable iff (!fifo1RstN)
    $rose(mail1Pending) |-> !mail1FlagN);
  // R5
  pend1_clear_chk: assert property (@(posedge clkB) disable iff (!fifo1RstN)
    $fell(mail1Pending) |-> $past(rdB1));
  // R10
  wr2_sets_flag_chk: assert property (@(posedge clkB) disable iff (!fifo2RstN)
    (wrB2 && mail2FlagN) |=> !mail2FlagN);
  // R10
  blocked2_chk: assert property (@(posedge clkB) disable iff (!fifo2RstN)
    !mail2FlagN |=> $stable(mbox2Q));
  // R10
  pend2_rise_chk: assert property (@(posedge clkA) disable iff (!fifo2RstN)
    $rose(mail2Pending) |-> !mail2FlagN);
  // R10
  pend2_clear_chk: assert property (@(posedge clkA) disable iff (!fifo2RstN)
    $fell(mail2Pending) |-> $past(rdA2));
endmodule

bind mailbox_bypass mailbox_bypass_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/mailbox_bypass_bench.sv
`timescale 1ns/1ps
module mailbox_bypass_bench;
  localparam int W = 36;

  logic clkA = 1'b0, clkB = 1'b0;
  real  halfB = 3.1;
  always #2.5 clkA = ~clkA;
  always #(halfB) clkB = ~clkB;

  logic fifo1RstN = 1'b0, fifo2RstN = 1'b0;
  logic selAN = 1'b1, dirWriteA = 1'b0, enA = 1'b0, mboxSelA = 1'b1;
  logic selBN = 1'b1, dirReadB = 1'b1, enB = 1'b0, mboxSelB = 1'b1;
  logic [W-1:0] dinA = '0, dinB = '0;
  logic [W-1:0] fifoOutA = 36'h0A5A5_1234, fifoOutB = 36'h05A5A_4321;
  logic [W-1:0] doutA, doutB;
  logic mail1FlagN, mail2FlagN, mail1Pending, mail2Pending;

  mailbox_bypass u_mailbox_bypass (.*);

  int nChecks = 0, nFail = 0;
  logic [W-1:0] exp1[$], exp2[$];
  logic [W-1:0] e1, e2;

  task automatic check(input bit ok, input string tag,
                       input logic [W-1:0] act, input logic [W-1:0] expv);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // Scoreboard monitors: compare the word on the reading port as a qualified read happens
  always @(negedge clkB) begin
    if (fifo1RstN && !selBN && dirReadB && enB && mboxSelB && mail1Pending) begin
      if (exp1.size() == 0) check(1'b0, "R1 unexpected mailbox1 read", doutB, '0);
      else begin
        e1 = exp1.pop_front();
        check(doutB == e1, "R1 mailbox1 word at port B", doutB, e1);
      end
    end
  end

  always @(negedge clkA) begin
    if (fifo2RstN && !selAN && !dirWriteA && enA && mboxSelA && mail2Pending) begin
      if (exp2.size() == 0) check(1'b0, "R10 unexpected mailbox2 read", doutA, '0);
      else begin
        e2 = exp2.pop_front();
        check(doutA == e2, "R10 mailbox2 word at port A", doutA, e2);
      end
    end
  end

  task automatic writeA(input logic [W-1:0] d, input bit taken);
    @(posedge clkA); #1;
    selAN = 1'b0; dirWriteA = 1'b1; enA = 1'b1; mboxSelA = 1'b1; dinA = d;
    if (taken) exp1.push_back(d);
    @(posedge clkA); #1;
    selAN = 1'b1; enA = 1'b0; dirWriteA = 1'b0;
    check(mail1FlagN == 1'b0, taken ? "R2 flag1 low after write" : "R3 flag1 stays low",
          W'(mail1FlagN), '0);
  endtask

  task automatic writeB(input logic [W-1:0] d, input bit taken);
    @(posedge clkB); #1;
    selBN = 1'b0; dirReadB = 1'b0; enB = 1'b1; mboxSelB = 1'b1; dinB = d;
    if (taken) exp2.push_back(d);
    @(posedge clkB); #1;
    selBN = 1'b1; enB = 1'b0; dirReadB = 1'b1;
    check(mail2FlagN == 1'b0, taken ? "R10 flag2 low after write" : "R10 flag2 stays low",
          W'(mail2FlagN), '0);
  endtask

  task automatic readB();
    @(posedge clkB); #1;
    selBN = 1'b0; dirReadB = 1'b1; enB = 1'b1; mboxSelB = 1'b1;
    @(posedge clkB); #1;
    selBN = 1'b1; enB = 1'b0;
  endtask

  task automatic readA();
    @(posedge clkA); #1;
    selAN = 1'b0; dirWriteA = 1'b0; enA = 1'b1; mboxSelA = 1'b1;
    @(posedge clkA); #1;
    selAN = 1'b1; enA = 1'b0;
  endtask

  task automatic roundTrip1(input logic [W-1:0] v1, input logic [W-1:0] v2);
    int n;
    writeA(v1, 1'b1);
    // R4: pending appears after the synchronizer, not before
    @(negedge clkB);
    check(!mail1Pending, "R4 pending1 not before sync", W'(mail1Pending), '0);
    n = 1;
    while (!mail1Pending && n < 6) begin @(negedge clkB); n++; end
    check(mail1Pending && n <= 4, "R4 pending1 within sync delay", W'(n), W'(4));
    // R3: second write refused, word unchanged
    writeA(v2, 1'b0);
    @(negedge clkB);
    check(doutB == v1, "R3 blocked write kept word1", doutB, v1);
    readB();
    check(!mail1Pending, "R5 pending1 cleared by read", W'(mail1Pending), '0);
    check(doutB == v1, "R6 word1 kept after read", doutB, v1);
    @(negedge clkA);
    check(!mail1FlagN, "R5 flag1 not back before sync", W'(mail1FlagN), '0);
    n = 1;
    while (!mail1FlagN && n < 6) begin @(negedge clkA); n++; end
    check(mail1FlagN && n <= 4, "R5 flag1 back within sync delay", W'(n), W'(4));
  endtask

  task automatic roundTrip2(input logic [W-1:0] v1, input logic [W-1:0] v2);
    int n;
    writeB(v1, 1'b1);
    @(negedge clkA);
    check(!mail2Pending, "R10 pending2 not before sync", W'(mail2Pending), '0);
    n = 1;
    while (!mail2Pending && n < 6) begin @(negedge clkA); n++; end
    check(mail2Pending && n <= 4, "R10 pending2 within sync delay", W'(n), W'(4));
    writeB(v2, 1'b0);
    @(negedge clkA);
    check(doutA == v1, "R10 blocked write kept word2", doutA, v1);
    readA();
    check(!mail2Pending, "R10 pending2 cleared by read", W'(mail2Pending), '0);
    check(doutA == v1, "R10 word2 kept after read", doutA, v1);
    @(negedge clkB);
    check(!mail2FlagN, "R10 flag2 not back before sync", W'(mail2FlagN), '0);
    n = 1;
    while (!mail2FlagN && n < 6) begin @(negedge clkB); n++; end
    check(mail2FlagN && n <= 4, "R10 flag2 back within sync delay", W'(n), W'(4));
  endtask

  initial begin
    #(200000 * 5);
    nChecks++; nFail++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clkA);
    #1.3;
    fifo1RstN = 1'b1; fifo2RstN = 1'b1;
    @(negedge clkA);
    // R8: reset state
    check(mail1FlagN && mail2FlagN, "R8 flags high after reset", W'({mail1FlagN, mail2FlagN}), W'(3));
    check(!mail1Pending && !mail2Pending, "R8 pending low after reset",
          W'({mail1Pending, mail2Pending}), '0);
    check(doutB == '0 && doutA == '0, "R8 mailboxes zero after reset", doutB | doutA, '0);
    // R9: output mux
    mboxSelB = 1'b0; mboxSelA = 1'b0; #1;
    check(doutB == fifoOutB, "R9 port B selects queue output", doutB, fifoOutB);
    check(doutA == fifoOutA, "R9 port A selects queue output", doutA, fifoOutA);
    mboxSelB = 1'b1; mboxSelA = 1'b1; #1;
    check(doutB == '0, "R9 port B selects mailbox1", doutB, '0);

    // R11: unqualified port A cycles store nothing
    @(posedge clkA); #1;
    selAN = 1'b0; dirWriteA = 1'b1; enA = 1'b0; mboxSelA = 1'b1; dinA = 36'hDEAD0BEEF;
    @(posedge clkA); #1;
    selAN = 1'b1; enA = 1'b1;
    @(posedge clkA); #1;
    selAN = 1'b0; mboxSelA = 1'b0;
    @(posedge clkA); #1;
    selAN = 1'b1; enA = 1'b0; dirWriteA = 1'b0; mboxSelA = 1'b1;
    check(mail1FlagN, "R11 flag1 high after unqualified cycles", W'(mail1FlagN), W'(1));
    check(doutB == '0, "R11 mailbox1 unchanged", doutB, '0);

    // R7: read with nothing pending
    readB();
    repeat (4) @(negedge clkA);
    check(!mail1Pending && mail1FlagN, "R7 idle read no effect",
          W'({mail1Pending, mail1FlagN}), W'(1));
    check(doutB == '0, "R7 idle read kept contents", doutB, '0);

    // Main traffic under several clock B phase relations
    foreach (phases[i]) begin
      halfB = phases[i];
      repeat (3) @(posedge clkB);
      roundTrip1(36'h1_0000_0001 * (i + 3) ^ 36'hF_00F0_0F0F, 36'h5_5555_5555);
      roundTrip2(36'h8_1234_5678 + 36'(i * 7919), 36'hA_AAAA_AAAA);
    end
    roundTrip1(36'hF_FFFF_FFFF, 36'h0_0000_0000);
    roundTrip2(36'h0_0000_0001, 36'hF_FFFF_FFFE);

    // R8: reset while mail is pending
    writeA(36'h3_C3C3_C3C3, 1'b0);
    @(negedge clkA); fifo1RstN = 1'b0;
    repeat (2) @(negedge clkA);
    fifo1RstN = 1'b1;
    #1;
    check(mail1FlagN && !mail1Pending, "R8 reset clears pending mail",
          W'({mail1FlagN, mail1Pending}), W'(2));
    check(doutB == '0, "R8 reset zeroes mailbox1", doutB, '0);
    roundTrip1(36'h7_0F0F_0F0F, 36'h1_1111_1111);

    repeat (4) @(posedge clkB);
    check(exp1.size() == 0 && exp2.size() == 0, "R1 all written words were read",
          W'(exp1.size() + exp2.size()), '0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

  real phases[5] = '{3.1, 2.2, 4.7, 1.8, 3.55};
endmodule